// File: doc/BRIEF.md
# Superscalar Register Rename Unit

This block converts the architectural register names of a decoded instruction group into physical register tags for an out-of-order core. The group has up to five slots. Each slot may read two logical sources and may write one logical destination. The unit holds two pieces of state: a mapping table from logical to physical registers, and a first-in first-out pool of unallocated physical registers.

Each destination receives a fresh physical tag. The tag that the destination replaces is reported so the core can release it when the instruction retires. A source that names a destination written by an earlier slot of the same group receives that slot's new tag. It does not receive the stale table entry.

The pool holds only six spare registers beyond the 32 architectural ones. The unit therefore holds the entire group when the pool or the 20-entry reorder window cannot take it all. Retirement returns replaced tags to the pool, up to five per cycle. The renamed tags are combinational outputs for the presented group. The state advances on the clock edge at which `rn_fire` is high.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i. The spare tags 32 to 37 are handed out in ascending order.
- R2: In an accepted group, the slots that have a destination take tags from the head of the pool in slot order, lowest slot first. Returned tags are queued behind those already in the pool, lower commit slot first.
- R3: A source takes the new tag of the highest-numbered earlier slot in the same group whose destination equals it. If no earlier slot writes it, the source takes the table entry. A slot's own destination never feeds its own sources.
- R4: `rn_pold` of a slot is the mapping its destination held just before that slot. This includes a mapping created by an earlier slot of the same group.
- R5: When the count of destinations in the valid slots exceeds the pool count, the group is held: `rn_stall` is 1, `rn_fire` is 0, and no tag, mapping or window entry is consumed.
- R6: Occupancy of the reorder window rises by the number of valid slots in each accepted group and falls by one for each set `cm_valid` bit. A group is held when the occupancy at the start of the cycle plus its valid slots exceeds 20.
- R7: Each commit slot with `cm_valid` and `cm_free` set returns `cm_tag` to the pool. The tag becomes usable from the next cycle, and not in the cycle it is returned.
- R8: After an accepted group, each written logical register maps to the tag of the last slot that wrote it. Later groups read that mapping.
- R9: With no valid slot, both `rn_fire` and `rn_stall` are 0. The two outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Slot holds an instruction |
| in_has_dst | input | 5 | Slot writes a destination |
| in_dst | input | 5x5 | Logical destination per slot |
| in_src1 | input | 5x5 | First logical source per slot |
| in_src2 | input | 5x5 | Second logical source per slot |
| cm_valid | input | 5 | An instruction retires in this commit slot |
| cm_free | input | 5 | The retiring instruction releases a tag |
| cm_tag | input | 5x6 | Physical tag released per commit slot |
| rn_fire | output | 1 | Group accepted this cycle |
| rn_stall | output | 1 | Group present but held |
| rn_psrc1 | output | 5x6 | Physical tag of first source per slot |
| rn_psrc2 | output | 5x6 | Physical tag of second source per slot |
| rn_pdst | output | 5x6 | New physical tag of destination per slot |
| rn_pold | output | 5x6 | Replaced physical tag of destination per slot |

## Verification
Allocation for a new group and the return of retired tags can fall in the same cycle. Both act on the pool count and on the window occupancy.

The bench provokes the overlap in two ways. In a directed case, the pool is empty and five tags are returned while a one-destination group is presented. In a long mixed run, random retirements accompany random groups on every cycle. The outcome is judged against a queue model in the bench. That model decides acceptance from the counts at the start of the cycle. It applies pops before pushes, and it checks that the held group is accepted one cycle later with the oldest returned tag.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int LOG_REGS  = 32;
    localparam int PHYS_REGS = 38;
    localparam int GROUP     = 5;
    localparam int ROB_SLOTS = 20;

    localparam int LW    = $clog2(LOG_REGS);
    localparam int PW    = $clog2(PHYS_REGS);
    localparam int SPARE = PHYS_REGS - LOG_REGS;
    localparam int CNT_W = $clog2(ROB_SLOTS + GROUP + 1);

    typedef logic [LW-1:0] lreg_t;
    typedef logic [PW-1:0] preg_t;

    // Per-slot rename result carried from the group logic to the outputs.
    typedef struct packed {
        preg_t src1;
        preg_t src2;
        preg_t dst;
        preg_t old;
    } rn_slot_t;

    function automatic logic [CNT_W-1:0] count_ones(input logic [GROUP-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < GROUP; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rename_pkg::*;
#(
    parameter int NLOG  = LOG_REGS,
    parameter int NPHYS = PHYS_REGS,
    parameter int W     = GROUP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      pop_n,
    input  logic [W-1:0]          push_en,
    input  logic [W-1:0][PW-1:0]  push_tag,
    output logic [CNT_W-1:0]      avail,
    output logic [W-1:0][PW-1:0]  head_tag
);
    localparam int FD = NPHYS - NLOG;
    localparam int IW = (FD > 1) ? $clog2(FD) : 1;

    logic [PW-1:0]         slots [FD];
    logic [IW-1:0]         head_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [W-1:0][IW-1:0]  wr_idx;
    logic [CNT_W-1:0]      push_n;

    // Read window at the head; pushes land past the occupied region.
    always_comb begin
        int rank;
        rank = 0;
        for (int k = 0; k < W; k++) begin
            head_tag[k] = slots[IW'((int'(head_q) + k) % FD)];
        end
        for (int j = 0; j < W; j++) begin
            wr_idx[j] = IW'((int'(head_q) + int'(cnt_q) + rank) % FD);
            if (push_en[j]) begin
                rank = rank + 1;
            end
        end
        push_n = CNT_W'(rank);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FD; i++) begin
                slots[i] <= PW'(NLOG + i);
            end
            head_q <= '0;
            cnt_q  <= CNT_W'(FD);
        end else begin
            for (int j = 0; j < W; j++) begin
                if (push_en[j]) begin
                    slots[wr_idx[j]] <= push_tag[j];
                end
            end
            head_q <= IW'((int'(head_q) + int'(pop_n)) % FD);
            cnt_q  <= cnt_q - pop_n + push_n;
        end
    end

    assign avail = cnt_q;

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rename_pkg::*;
#(
    parameter int NLOG = LOG_REGS,
    parameter int W    = GROUP,
    parameter int NRD  = 3 * GROUP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRD-1:0][LW-1:0] rd_addr,
    output logic [NRD-1:0][PW-1:0] rd_data,
    input  logic [W-1:0]           wr_en,
    input  logic [W-1:0][LW-1:0]   wr_addr,
    input  logic [W-1:0][PW-1:0]   wr_data
);
    logic [PW-1:0] map_q [NLOG];

    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rd_data[r] = map_q[rd_addr[r]];
        end
    end

    // Ascending slot order: the highest writing slot wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLOG; i++) begin
                map_q[i] <= PW'(i);
            end
        end else begin
            for (int j = 0; j < W; j++) begin
                if (wr_en[j]) begin
                    map_q[wr_addr[j]] <= wr_data[j];
                end
            end
        end
    end

endmodule

// File: rtl/rn_group_bypass.sv
module rn_group_bypass
    import rename_pkg::*;
#(
    parameter int W = GROUP
) (
    input  logic [W-1:0]          in_valid,
    input  logic [W-1:0]          in_has_dst,
    input  logic [W-1:0][LW-1:0]  in_dst,
    input  logic [W-1:0][LW-1:0]  in_src1,
    input  logic [W-1:0][LW-1:0]  in_src2,
    input  logic [W-1:0][PW-1:0]  map_s1,
    input  logic [W-1:0][PW-1:0]  map_s2,
    input  logic [W-1:0][PW-1:0]  map_d,
    input  logic [W-1:0][PW-1:0]  head_tag,
    output rn_slot_t [W-1:0]      res,
    output logic [CNT_W-1:0]      ndst,
    output logic [CNT_W-1:0]      nvalid
);
    localparam int SW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] writes;

    assign writes = in_valid & in_has_dst;

    always_comb begin
        int rank;
        rank = 0;
        // Destination tags: compacted over writing slots.
        for (int i = 0; i < W; i++) begin
            res[i].dst = '0;
            if (writes[i]) begin
                res[i].dst = head_tag[SW'(rank)];
                rank = rank + 1;
            end
        end
        ndst = CNT_W'(rank);
        // Sources and old mapping: latest earlier writer overrides the table.
        for (int i = 0; i < W; i++) begin
            res[i].src1 = map_s1[i];
            res[i].src2 = map_s2[i];
            res[i].old  = map_d[i];
            for (int j = 0; j < W; j++) begin
                if (j < i && writes[j]) begin
                    if (in_dst[j] == in_src1[i]) res[i].src1 = res[j].dst;
                    if (in_dst[j] == in_src2[i]) res[i].src2 = res[j].dst;
                    if (in_dst[j] == in_dst[i])  res[i].old  = res[j].dst;
                end
            end
        end
        nvalid = count_ones(in_valid);
    end

endmodule

// File: rtl/rn_rob_credit.sv
module rn_rob_credit
    import rename_pkg::*;
#(
    parameter int DEPTH = ROB_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] req_n,
    input  logic [CNT_W-1:0] alloc_n,
    input  logic [CNT_W-1:0] retire_n,
    output logic             room,
    output logic [CNT_W-1:0] occ
);
    logic [CNT_W-1:0] occ_q;

    assign room = (int'(occ_q) + int'(req_n)) <= DEPTH;
    assign occ  = occ_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + alloc_n - retire_n;
        end
    end

endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rename_pkg::*;
#(
    parameter int NLOG  = LOG_REGS,
    parameter int NPHYS = PHYS_REGS,
    parameter int W     = GROUP,
    parameter int ROB   = ROB_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         in_valid,
    input  logic [W-1:0]         in_has_dst,
    input  logic [W-1:0][LW-1:0] in_dst,
    input  logic [W-1:0][LW-1:0] in_src1,
    input  logic [W-1:0][LW-1:0] in_src2,
    input  logic [W-1:0]         cm_valid,
    input  logic [W-1:0]         cm_free,
    input  logic [W-1:0][PW-1:0] cm_tag,
    output logic                 rn_fire,
    output logic                 rn_stall,
    output logic [W-1:0][PW-1:0] rn_psrc1,
    output logic [W-1:0][PW-1:0] rn_psrc2,
    output logic [W-1:0][PW-1:0] rn_pdst,
    output logic [W-1:0][PW-1:0] rn_pold
);
    localparam int NRD = 3 * W;

    logic [NRD-1:0][LW-1:0] rd_addr;
    logic [NRD-1:0][PW-1:0] rd_data;
    logic [W-1:0][PW-1:0]   map_s1, map_s2, map_d;
    logic [W-1:0][PW-1:0]   head_tag;
    logic [W-1:0][PW-1:0]   new_tag;
    rn_slot_t [W-1:0]       res;
    logic [CNT_W-1:0]       ndst, nvalid, free_avail, rob_occ;
    logic [CNT_W-1:0]       pop_n, alloc_n, retire_n;
    logic                   rob_room, any_valid;
    logic [W-1:0]           map_we;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            rd_addr[i]       = in_src1[i];
            rd_addr[W + i]   = in_src2[i];
            rd_addr[2*W + i] = in_dst[i];
            map_s1[i]        = rd_data[i];
            map_s2[i]        = rd_data[W + i];
            map_d[i]         = rd_data[2*W + i];
            new_tag[i]       = res[i].dst;
            rn_psrc1[i]      = res[i].src1;
            rn_psrc2[i]      = res[i].src2;
            rn_pdst[i]       = res[i].dst;
            rn_pold[i]       = res[i].old;
        end
    end

    assign any_valid = |in_valid;
    assign rn_fire   = any_valid && (ndst <= free_avail) && rob_room;
    assign rn_stall  = any_valid && !rn_fire;
    assign pop_n     = rn_fire ? ndst : '0;
    assign alloc_n   = rn_fire ? nvalid : '0;
    assign retire_n  = count_ones(cm_valid);
    assign map_we    = {W{rn_fire}} & in_valid & in_has_dst;

    rn_map_table #(.NLOG(NLOG), .W(W), .NRD(NRD)) u_map (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (map_we),
        .wr_addr (in_dst),
        .wr_data (new_tag)
    );

    rn_free_list #(.NLOG(NLOG), .NPHYS(NPHYS), .W(W)) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop_n    (pop_n),
        .push_en  (cm_valid & cm_free),
        .push_tag (cm_tag),
        .avail    (free_avail),
        .head_tag (head_tag)
    );

    rn_group_bypass #(.W(W)) u_group (
        .in_valid   (in_valid),
        .in_has_dst (in_has_dst),
        .in_dst     (in_dst),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .map_s1     (map_s1),
        .map_s2     (map_s2),
        .map_d      (map_d),
        .head_tag   (head_tag),
        .res        (res),
        .ndst       (ndst),
        .nvalid     (nvalid)
    );

    rn_rob_credit #(.DEPTH(ROB)) u_rob (
        .clk      (clk),
        .rst      (rst),
        .req_n    (nvalid),
        .alloc_n  (alloc_n),
        .retire_n (retire_n),
        .room     (rob_room),
        .occ      (rob_occ)
    );

endmodule

// File: rtl/rn_checker.sv
module rn_checker
    import rename_pkg::*;
#(
    parameter int W   = GROUP,
    parameter int ROB = ROB_SLOTS,
    parameter int FD  = SPARE
) (
    input logic                 clk,
    input logic                 rst,
    input logic [W-1:0]         in_valid,
    input logic [W-1:0]         in_has_dst,
    input logic [W-1:0][LW-1:0] in_dst,
    input logic [W-1:0][LW-1:0] in_src1,
    input logic [W-1:0]         cm_valid,
    input logic [W-1:0]         cm_free,
    input logic                 rn_fire,
    input logic                 rn_stall,
    input logic [W-1:0][PW-1:0] rn_psrc1,
    input logic [W-1:0][PW-1:0] rn_pdst,
    input logic [CNT_W-1:0]     free_avail,
    input logic [CNT_W-1:0]     rob_occ
);
    logic [CNT_W-1:0] npush;
    assign npush = count_ones(cm_valid & cm_free);

    AST_FIRE_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rn_fire && rn_stall)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|in_valid) |-> (!rn_fire && !rn_stall)); // R9

    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
        free_avail <= CNT_W'(FD)); // R5

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        rob_occ <= CNT_W'(ROB)); // R6

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (rn_stall && !(|cm_valid)) |=> ($stable(free_avail) && $stable(rob_occ))); // R5

    AST_RETURN_NEXT: assert property (@(posedge clk) disable iff (rst)
        !rn_fire |=> free_avail == $past(free_avail) + $past(npush)); // R7

    AST_SLOT1_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (rn_fire && in_valid[0] && in_valid[1] && in_has_dst[0] && in_src1[1] == in_dst[0])
        |-> rn_psrc1[1] == rn_pdst[0]); // R3

    AST_FRESH_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (rn_fire && in_valid[0] && in_valid[1] && in_has_dst[0] && in_has_dst[1])
        |-> rn_pdst[0] != rn_pdst[1]); // R2

endmodule

bind reg_rename rn_checker #(.W(W), .ROB(ROB), .FD(NPHYS - NLOG)) u_rn_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_has_dst (in_has_dst),
    .in_dst     (in_dst),
    .in_src1    (in_src1),
    .cm_valid   (cm_valid),
    .cm_free    (cm_free),
    .rn_fire    (rn_fire),
    .rn_stall   (rn_stall),
    .rn_psrc1   (rn_psrc1),
    .rn_pdst    (rn_pdst),
    .free_avail (free_avail),
    .rob_occ    (rob_occ)
);

// File: tb/test_reg_rename.sv
module test_reg_rename;
    import rename_pkg::*;

    localparam int W  = GROUP;
    localparam int NL = LOG_REGS;
    localparam int RD = ROB_SLOTS;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0]         in_valid, in_has_dst, cm_valid, cm_free;
    logic [W-1:0][LW-1:0] in_dst, in_src1, in_src2;
    logic [W-1:0][PW-1:0] cm_tag;
    logic                 rn_fire, rn_stall;
    logic [W-1:0][PW-1:0] rn_psrc1, rn_psrc2, rn_pdst, rn_pold;

    reg_rename i_reg_rename (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .cm_valid(cm_valid), .cm_free(cm_free), .cm_tag(cm_tag),
        .rn_fire(rn_fire), .rn_stall(rn_stall), .rn_psrc1(rn_psrc1),
        .rn_psrc2(rn_psrc2), .rn_pdst(rn_pdst), .rn_pold(rn_pold)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int mmap[NL];
    int tmap[NL];
    int freeq[$];
    int rob_has[$];
    int rob_tag[$];
    int exp_s1[W], exp_s2[W], exp_d[W], exp_o[W];
    int exp_nd;
    bit exp_fire;
    bit [31:0] seed = 32'h2545F491;

    function automatic int rnd(int m);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed % m);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_has_dst = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        cm_valid = '0; cm_free = '0; cm_tag = '0;
    endtask

    task automatic set_slot(int i, bit hd, int d, int s1, int s2);
        in_valid[i] = 1'b1; in_has_dst[i] = hd;
        in_dst[i] = LW'(d); in_src1[i] = LW'(s1); in_src2[i] = LW'(s2);
    endtask

    task automatic set_commit(int n);
        for (int k = 0; k < n; k++) begin
            cm_valid[k] = 1'b1;
            cm_free[k]  = rob_has[k] != 0;
            cm_tag[k]   = PW'(rob_tag[k]);
        end
    endtask

    // Sequential reference: slots renamed one after another.
    task automatic predict();
        int nv, r;
        nv = 0; exp_nd = 0;
        for (int i = 0; i < W; i++) begin
            if (in_valid[i]) begin
                nv++;
                if (in_has_dst[i]) exp_nd++;
            end
        end
        exp_fire = nv > 0 && exp_nd <= freeq.size() && rob_has.size() + nv <= RD;
        tmap = mmap; r = 0;
        for (int i = 0; i < W; i++) begin
            if (in_valid[i]) begin
                exp_s1[i] = tmap[in_src1[i]];
                exp_s2[i] = tmap[in_src2[i]];
                if (in_has_dst[i]) begin
                    exp_o[i] = tmap[in_dst[i]];
                    exp_d[i] = (r < freeq.size()) ? freeq[r] : -1;
                    r++;
                    tmap[in_dst[i]] = exp_d[i];
                end
            end
        end
        chk("R5 fire", int'(rn_fire), int'(exp_fire));
        chk("R9 stall", int'(rn_stall), int'(nv > 0 && !exp_fire));
        if (exp_fire) begin
            for (int i = 0; i < W; i++) begin
                if (in_valid[i]) begin
                    chk("R3 src1", int'(rn_psrc1[i]), exp_s1[i]);
                    chk("R3 src2", int'(rn_psrc2[i]), exp_s2[i]);
                    if (in_has_dst[i]) begin
                        chk("R2 pdst", int'(rn_pdst[i]), exp_d[i]);
                        chk("R4 pold", int'(rn_pold[i]), exp_o[i]);
                    end
                end
            end
        end
    endtask

    task automatic step();
        #1;
        predict();
    endtask

    task automatic tick();
        int h, t;
        @(posedge clk);
        if (exp_fire) begin
            for (int k = 0; k < exp_nd; k++) void'(freeq.pop_front());
            mmap = tmap;
            for (int i = 0; i < W; i++) begin
                if (in_valid[i]) begin
                    rob_has.push_back(int'(in_has_dst[i]));
                    rob_tag.push_back(in_has_dst[i] ? exp_o[i] : 0);
                end
            end
        end
        for (int k = 0; k < W; k++) begin
            if (cm_valid[k]) begin
                h = rob_has.pop_front();
                t = rob_tag.pop_front();
                if (h != 0) freeq.push_back(t);
            end
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic drain();
        int n;
        while (rob_has.size() > 0) begin
            n = (rob_has.size() < W) ? rob_has.size() : W;
            set_commit(n);
            step();
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int last_w;
        int n;
        clear_in();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NL; i++) mmap[i] = i;
        for (int i = 0; i < SPARE; i++) freeq.push_back(NL + i);

        // R9: idle group
        step();
        chk("R9 idle fire", int'(rn_fire), 0);
        tick();

        // R1: identity map on sources
        for (int i = 0; i < W; i++) set_slot(i, 0, 0, i, 31 - i);
        step();
        for (int i = 0; i < W; i++) begin
            chk("R1 src1 identity", int'(rn_psrc1[i]), i);
            chk("R1 src2 identity", int'(rn_psrc2[i]), 31 - i);
        end
        tick();

        // R1: spare tags issued ascending
        for (int i = 0; i < W; i++) set_slot(i, 1, i + 1, 0, 0);
        step();
        for (int i = 0; i < W; i++) begin
            chk("R1 first pdst", int'(rn_pdst[i]), 32 + i);
            chk("R1 first pold", int'(rn_pold[i]), i + 1);
        end
        tick();

        // R5: one tag left, two requested
        set_slot(0, 1, 9, 0, 0); set_slot(1, 1, 10, 0, 0);
        step();
        chk("R5 short stall", int'(rn_stall), 1);
        tick();
        set_slot(0, 1, 9, 1, 0);
        step();
        chk("R5 nothing consumed", int'(rn_pdst[0]), 37);
        chk("R8 mapping updated", int'(rn_psrc1[0]), 32);
        tick();

        // R7: retire and rename in the same cycle with an empty pool
        set_commit(5); set_slot(0, 1, 11, 0, 0);
        step();
        chk("R5 empty pool stall", int'(rn_stall), 1);
        tick();
        set_commit(5); set_slot(0, 1, 12, 0, 0);
        step();
        chk("R7 not usable same cycle", int'(rn_stall), 1);
        tick();
        set_slot(0, 1, 12, 0, 0);
        step();
        chk("R7 returned tag reused", int'(rn_pdst[0]), 1);
        tick();
        drain();

        // R6: fill the reorder window
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < W; i++) set_slot(i, 0, 0, i, i);
            step();
            tick();
        end
        set_slot(0, 0, 0, 0, 0);
        step();
        chk("R6 window full stall", int'(rn_stall), 1);
        tick();
        set_commit(1); set_slot(0, 0, 0, 0, 0);
        step();
        chk("R6 start-of-cycle occupancy", int'(rn_stall), 1);
        tick();
        set_slot(0, 0, 0, 0, 0);
        step();
        chk("R6 resumes", int'(rn_fire), 1);
        tick();
        drain();

        // R3/R4/R8: chained writers of one logical register
        set_slot(0, 1, 7, 3, 4); set_slot(1, 1, 7, 7, 7); set_slot(2, 1, 8, 7, 7);
        step();
        chk("R3 bypass from slot0", int'(rn_psrc1[1]), exp_d[0]);
        chk("R4 old from slot0", int'(rn_pold[1]), exp_d[0]);
        chk("R3 latest writer", int'(rn_psrc2[2]), exp_d[1]);
        chk("R3 own dst not used", int'(rn_psrc1[0]), mmap[3]);
        last_w = exp_d[1];
        tick();
        set_slot(0, 0, 0, 7, 7);
        step();
        chk("R8 last writer wins", int'(rn_psrc1[0]), last_w);
        tick();

        // Mixed sweep: random groups with concurrent retirement
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < W; i++) begin
                if (rnd(4) != 0) set_slot(i, rnd(2) != 0, rnd(8), rnd(8), rnd(8));
            end
            n = rnd(W + 1);
            if (n > rob_has.size()) n = rob_has.size();
            set_commit(n);
            step();
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule